// File: doc/BRIEF.md
# Windowed Auto-Increment I2C Register Slave

This block is a standard-mode I2C slave that gives a host microcontroller access to a 50-entry byte register space at word addresses 0x00 to 0x31. Before any address decoding, the open-drain SCL and SDA levels pass through a two-flop synchronizer. The block decodes START and STOP itself and, in the ninth clock of a byte, acknowledges by pulling SDA low through `sda_oe`. Each transfer to the slave begins with a word address and then reads or writes data bytes. A single strap pin chooses between two 7-bit device addresses.

Auto-increment of the word address happens only inside two windows. The window 0x02..0x0F covers one data area and stops at 0x0F. The window 0x11..0x31 covers a second data area and stops at 0x31. The control/status location 0x00, the interrupt-enable location 0x01, the spare location 0x10 and every address above 0x31 are reached only by direct addressing. On the core side, `reg_addr` carries the current word address. The core returns that location's byte on `rd_data` combinationally. `wr_valid` offers one write per byte, and it fires only for the two host-writable control locations. SCL is never stretched, so the write stream has no ready signal: the core must accept a write in the cycle `wr_valid` is high. `status_rd` pulses once each time the status byte has been shifted out to the host, so that the core can clear its received flags and release its interrupt line.

Top module: `i2cw_slave`

## Requirements
- R1: The slave acknowledges a device address byte only when its upper seven bits equal 0x11 with `addr_sel` low, or 0x10 with `addr_sel` high. The lowest bit is the read/write flag, 1 meaning read. A byte with any other address gets no acknowledge and is ignored until the next START.
- R2: The slave acknowledges (SDA low during the ninth clock) the word address byte and every data byte written to it.
- R3: A word address in 0x02..0x0E advances by one after each acknowledged data byte. On reaching 0x0F it holds, so later bytes of the same transfer use 0x0F.
- R4: A word address in 0x11..0x30 advances by one after each acknowledged data byte. On reaching 0x31 it holds.
- R5: Word addresses 0x00, 0x01, 0x10 and anything above 0x31 never advance. Every byte of a transfer uses the addressed location.
- R6: During a read, the address advances only when the host acknowledges the byte. After a byte the host does not acknowledge, `reg_addr` stays at that byte's location.
- R7: `wr_valid` goes high for exactly one clock, with `reg_addr` at the target and the received byte on `wr_data`, only for writes to 0x00 or 0x01. Writes to any other location are acknowledged and produce no `wr_valid`.
- R8: Read data goes out MSB first. Locations 0x00, 0x02..0x0F and 0x11..0x31 return `rd_data` for the current `reg_addr`. Locations 0x01, 0x10 and anything above 0x31 return 0x00.
- R9: `status_rd` pulses for one clock once per byte read from location 0x00, in the host's acknowledge clock, whether or not the host acknowledges. It stays low for every other location.
- R10: A STOP or a START, including one in the middle of a byte, returns the slave to waiting for a device address without writing anything. The word address is kept across transfers, so a read without a new word address continues from the last location.
- R11: After reset, `sda_oe`, `wr_valid` and `status_rd` are low and `reg_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level at the pad |
| sda_i | input | 1 | SDA level at the pad |
| sda_oe | output | 1 | Drive SDA low when high, release it when low |
| addr_sel | input | 1 | Device address strap: low selects 0x11, high selects 0x10 |
| reg_addr | output | 8 | Current word address toward the register file |
| rd_data | input | 8 | Byte at `reg_addr`, returned combinationally by the core |
| wr_valid | output | 1 | One-clock write strobe for the control locations |
| wr_data | output | 8 | Byte to be written while `wr_valid` is high |
| status_rd | output | 1 | One-clock pulse after the status byte has been read |

## Verification
The assertions assume SCL edges at least several clocks apart, so that every synchronized edge is seen and handled before the next one. They also assume a single host that changes SDA only while SCL is low, except when it deliberately makes a START or STOP. The stimulus keeps to this by running each bit in four equal quarters of six clocks, changing SDA in the second quarter of the low phase and sampling in the second quarter of the high phase. The address-stepping checks also assume that `reg_addr` changes only through a loaded word address or a window step.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  localparam int BYTE_W = 8;

  // Register space landmarks; the stepping and decode behaviour depends on these.
  localparam logic [BYTE_W-1:0] CTRL_LOC    = 8'h00;
  localparam logic [BYTE_W-1:0] IRQ_LOC     = 8'h01;
  localparam logic [BYTE_W-1:0] WIN_A_FIRST = 8'h02;
  localparam logic [BYTE_W-1:0] WIN_A_STOP  = 8'h0F;
  localparam logic [BYTE_W-1:0] WIN_B_FIRST = 8'h11;
  localparam logic [BYTE_W-1:0] WIN_B_STOP  = 8'h31;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_DEV,
    LK_DEV_ACK,
    LK_WADDR,
    LK_WADDR_ACK,
    LK_WDATA,
    LK_WDATA_ACK,
    LK_RDATA,
    LK_RACK
  } link_state_t;

  // Address lies in a window and below that window's stop value.
  function automatic logic addr_steps(input logic [BYTE_W-1:0] a);
    return ((a >= WIN_A_FIRST) && (a < WIN_A_STOP)) ||
           ((a >= WIN_B_FIRST) && (a < WIN_B_STOP));
  endfunction

  function automatic logic addr_readable(input logic [BYTE_W-1:0] a);
    return (a == CTRL_LOC) ||
           ((a >= WIN_A_FIRST) && (a <= WIN_A_STOP)) ||
           ((a >= WIN_B_FIRST) && (a <= WIN_B_STOP));
  endfunction

  function automatic logic addr_writable(input logic [BYTE_W-1:0] a);
    return (a == CTRL_LOC) || (a == IRQ_LOC);
  endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2cw_addr_ptr.sv
module i2cw_addr_ptr
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              step,
  output logic [BYTE_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          addr <= '0;
    else if (load)                       addr <= load_val;
    else if (step && addr_steps(addr))   addr <= addr + 1'b1;
  end
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        dev_id,
  input  logic [BYTE_W-1:0] cur_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              addr_load,
  output logic [BYTE_W-1:0] addr_val,
  output logic              addr_step,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              status_rd
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  link_state_t       st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rw;
  logic              host_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LK_IDLE;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rw        <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      addr_load <= 1'b0;
      addr_val  <= '0;
      addr_step <= 1'b0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      status_rd <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      addr_step <= 1'b0;
      wr_valid  <= 1'b0;
      status_rd <= 1'b0;
      if (start_det) begin
        st     <= LK_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          LK_DEV, LK_WADDR, LK_WDATA: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              cnt <= '0;
              if (st == LK_DEV) begin
                if (rx_sh[BYTE_W-1:1] == dev_id) begin
                  rw     <= rx_sh[0];
                  sda_oe <= 1'b1;
                  st     <= LK_DEV_ACK;
                end else begin
                  st <= LK_IDLE;
                end
              end else if (st == LK_WADDR) begin
                addr_load <= 1'b1;
                addr_val  <= rx_sh;
                sda_oe    <= 1'b1;
                st        <= LK_WADDR_ACK;
              end else begin
                wr_valid <= addr_writable(cur_addr);
                wr_data  <= rx_sh;
                sda_oe   <= 1'b1;
                st       <= LK_WDATA_ACK;
              end
            end
          end
          LK_DEV_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx_sh  <= {rd_byte[BYTE_W-2:0], 1'b0};
                sda_oe <= ~rd_byte[BYTE_W-1];
                st     <= LK_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= LK_WADDR;
              end
            end
          end
          LK_WADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= LK_WDATA;
            end
          end
          LK_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe    <= 1'b0;
              addr_step <= 1'b1;
              cnt       <= '0;
              st        <= LK_WDATA;
            end
          end
          LK_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                st     <= LK_RACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          LK_RACK: begin
            if (scl_rise) begin
              host_ack  <= ~sda_lvl;
              addr_step <= ~sda_lvl;
              status_rd <= (cur_addr == CTRL_LOC);
            end else if (scl_fall) begin
              cnt <= '0;
              if (host_ack) begin
                tx_sh  <= {rd_byte[BYTE_W-2:0], 1'b0};
                sda_oe <= ~rd_byte[BYTE_W-1];
                st     <= LK_RDATA;
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ID_STRAP_LO = 7'h11,
  parameter logic [6:0] DEV_ID_STRAP_HI = 7'h10,
  parameter int         SYNC_DEPTH      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  output logic [BYTE_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              status_rd
);
  localparam int NLINES = 2;
  localparam int L_SCL  = 0;
  localparam int L_SDA  = 1;

  logic [NLINES-1:0] pin_in, lvl, rise, fall;
  assign pin_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2cw_sync #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in[g]),
      .lvl  (lvl[g]),
      .rise (rise[g]),
      .fall (fall[g])
    );
  end

  logic start_det, stop_det;
  assign start_det = fall[L_SDA] & lvl[L_SCL];
  assign stop_det  = rise[L_SDA] & lvl[L_SCL];

  logic [6:0]        dev_id;
  logic [BYTE_W-1:0] rd_byte;
  logic              addr_load, addr_step;
  logic [BYTE_W-1:0] addr_val;

  assign dev_id  = addr_sel ? DEV_ID_STRAP_HI : DEV_ID_STRAP_LO;
  assign rd_byte = addr_readable(reg_addr) ? rd_data : '0;

  i2cw_addr_ptr u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (addr_load),
    .load_val(addr_val),
    .step    (addr_step),
    .addr    (reg_addr)
  );

  i2cw_link u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (rise[L_SCL]),
    .scl_fall (fall[L_SCL]),
    .sda_lvl  (lvl[L_SDA]),
    .start_det(start_det),
    .stop_det (stop_det),
    .dev_id   (dev_id),
    .cur_addr (reg_addr),
    .rd_byte  (rd_byte),
    .sda_oe   (sda_oe),
    .addr_load(addr_load),
    .addr_val (addr_val),
    .addr_step(addr_step),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .status_rd(status_rd)
  );
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic       wr_valid,
  input logic       status_rd,
  input logic       sda_oe,
  input logic       addr_load
);
  // R11: the bus is released when reset ends
  a_r11_released_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sda_oe);

  // R3: stop value of the low window holds unless a new word address is loaded
  a_r3_stop_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) == 8'h0F && !$past(addr_load)) |-> reg_addr == 8'h0F);

  // R4: stop value of the high window holds
  a_r4_stop_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) == 8'h31 && !$past(addr_load)) |-> reg_addr == 8'h31);

  // R5: direct-only locations never advance on their own
  a_r5_direct_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(reg_addr) == 8'h00 || $past(reg_addr) == 8'h01 ||
      $past(reg_addr) == 8'h10 || $past(reg_addr) > 8'h31) && !$past(addr_load))
    |-> $stable(reg_addr));

  // R3 and R4: any change without a load is a single step up
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(addr_load) && !$stable(reg_addr)) |-> reg_addr == $past(reg_addr) + 8'd1);

  // R7: writes reach the core only for the control locations, one clock each
  a_r7_write_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> reg_addr <= 8'h01);

  a_r7_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R9: status pulse only at the status location, one clock wide
  a_r9_status_at_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |-> reg_addr == 8'h00);

  a_r9_status_single: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !status_rd);
endmodule

bind i2cw_slave i2cw_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .wr_valid (wr_valid),
  .status_rd(status_rd),
  .sda_oe   (sda_oe),
  .addr_load(addr_load)
);

// File: tb/i2cw_slave_test.sv
module i2cw_slave_test;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, addr_sel = 1'b0;
  logic sda_oe, wr_valid, status_rd;
  logic [7:0] reg_addr, rd_data, wr_data;
  wire sda_line = ~(m_low | sda_oe);

  // core model: each location holds a*7+3
  assign rd_data = reg_addr * 8'd7 + 8'd3;

  i2cw_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .reg_addr(reg_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .status_rd(status_rd)
  );

  int total = 0, bad = 0, wr_cnt = 0, st_cnt = 0;
  logic [7:0] last_wa = 8'h00, last_wd = 8'h00;

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_cnt++;
      last_wa = reg_addr;
      last_wd = wr_data;
    end
    if (status_rd) st_cnt++;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input bit b, output bit s);
    w(Q); m_low = ~b; w(Q); scl = 1'b1; w(Q); s = sda_line; w(Q); scl = 1'b0;
  endtask

  task automatic b_start;
    m_low = 1'b0; scl = 1'b1; w(Q); m_low = 1'b1; w(2*Q); scl = 1'b0;
  endtask

  task automatic b_rstart;
    w(Q); m_low = 1'b0; w(Q); scl = 1'b1; w(Q); m_low = 1'b1; w(Q); scl = 1'b0;
  endtask

  task automatic b_stop;
    w(Q); m_low = 1'b1; w(Q); scl = 1'b1; w(2*Q); m_low = 1'b0; w(4*Q);
  endtask

  task automatic tx_byte(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rx_byte(input bit mack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(!mack, s);
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] a);
    if ((a >= 8'd2 && a <= 8'd14) || (a >= 8'd17 && a <= 8'd48)) return a + 8'd1;
    return a;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'd0 || (a >= 8'd2 && a <= 8'd15) || (a >= 8'd17 && a <= 8'd49))
      return a * 8'd7 + 8'd3;
    return 8'h00;
  endfunction

  function automatic string rq(input logic [7:0] a);
    if (a <= 8'd1 || a == 8'd16 || a >= 8'd50) return "R5";
    if (a <= 8'd15) return "R3";
    return "R4";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int c0;
    w(5); rst_n = 1'b1; w(3);
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);
    chk(wr_valid == 1'b0, "R11", wr_valid, 0);
    chk(status_rd == 1'b0, "R11", status_rd, 0);
    chk(reg_addr == 8'h00, "R11", reg_addr, 0);

    // R1: device address matching for both strap values
    for (int sel = 0; sel < 2; sel++) begin
      addr_sel = sel[0];
      for (int k = 0; k < 4; k++) begin
        logic [6:0] dev;
        bit want;
        dev = (k == 0) ? 7'h10 : (k == 1) ? 7'h11 : (k == 2) ? 7'h12 : 7'h51;
        want = (dev == (sel[0] ? 7'h10 : 7'h11));
        b_start; tx_byte({dev, 1'b0}, ack); b_stop;
        chk(ack == want, "R1", ack, want);
      end
    end
    addr_sel = 1'b0;

    // Read sweep over every location and two more: R2 R3 R4 R5 R6 R8 R9
    for (int a = 0; a < 52; a++) begin
      logic [7:0] a0, a1, a2;
      int s0;
      a0 = 8'(a); a1 = nxt(a0); a2 = nxt(a1);
      b_start; tx_byte(8'h22, ack); tx_byte(a0, ack);
      chk(ack, "R2", ack, 1);
      b_rstart; tx_byte(8'h23, ack);
      s0 = st_cnt;
      rx_byte(1'b1, d); chk(d == exp_rd(a0), "R8", d, exp_rd(a0));
      rx_byte(1'b1, d); chk(d == exp_rd(a1), rq(a0), d, exp_rd(a1));
      rx_byte(1'b0, d); chk(d == exp_rd(a2), rq(a0), d, exp_rd(a2));
      b_stop;
      chk(st_cnt - s0 == ((a0 == 8'd0) ? 3 : 0), "R9", st_cnt - s0, (a0 == 8'd0) ? 3 : 0);
      chk(reg_addr == a2, "R6", reg_addr, a2);
    end

    // Write sweep: R2 R7
    for (int a = 0; a < 52; a++) begin
      logic [7:0] v;
      v = 8'(a) ^ 8'hA5;
      c0 = wr_cnt;
      b_start; tx_byte(8'h22, ack); tx_byte(8'(a), ack); tx_byte(v, ack); b_stop;
      chk(ack, "R2", ack, 1);
      chk(wr_cnt - c0 == ((a <= 1) ? 1 : 0), "R7", wr_cnt - c0, (a <= 1) ? 1 : 0);
      if (a <= 1) chk(last_wa == 8'(a) && last_wd == v, "R7", {last_wa, last_wd}, {8'(a), v});
    end

    // Write bursts across stop values and on direct locations
    b_start; tx_byte(8'h22, ack); tx_byte(8'h0E, ack);
    for (int i = 0; i < 3; i++) tx_byte(8'h5C, ack);
    b_stop; chk(reg_addr == 8'h0F, "R3", reg_addr, 8'h0F);

    b_start; tx_byte(8'h22, ack); tx_byte(8'h30, ack);
    for (int i = 0; i < 3; i++) tx_byte(8'h5C, ack);
    b_stop; chk(reg_addr == 8'h31, "R4", reg_addr, 8'h31);

    c0 = wr_cnt;
    b_start; tx_byte(8'h22, ack); tx_byte(8'h00, ack);
    tx_byte(8'h13, ack); tx_byte(8'h12, ack); b_stop;
    chk(wr_cnt - c0 == 2 && last_wa == 8'h00 && last_wd == 8'h12, "R7", wr_cnt - c0, 2);
    chk(reg_addr == 8'h00, "R5", reg_addr, 0);

    b_start; tx_byte(8'h22, ack); tx_byte(8'h10, ack);
    tx_byte(8'h01, ack); tx_byte(8'h02, ack); b_stop;
    chk(reg_addr == 8'h10, "R5", reg_addr, 8'h10);

    // R10: word address kept across transfers
    b_start; tx_byte(8'h22, ack); tx_byte(8'h07, ack); b_stop;
    b_start; tx_byte(8'h23, ack); rx_byte(1'b0, d); b_stop;
    chk(d == exp_rd(8'h07), "R10", d, exp_rd(8'h07));

    // R10: STOP in the middle of a data byte writes nothing
    c0 = wr_cnt;
    b_start; tx_byte(8'h22, ack); tx_byte(8'h01, ack);
    begin
      bit s;
      bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
    end
    b_stop;
    chk(wr_cnt == c0, "R10", wr_cnt - c0, 0);
    chk(reg_addr == 8'h01, "R10", reg_addr, 1);

    // R1: other strap value reaches the register space too
    addr_sel = 1'b1;
    b_start; tx_byte(8'h20, ack); tx_byte(8'h12, ack);
    b_rstart; tx_byte(8'h21, ack);
    chk(ack, "R1", ack, 1);
    rx_byte(1'b1, d); chk(d == exp_rd(8'h12), "R1", d, exp_rd(8'h12));
    rx_byte(1'b0, d); chk(d == exp_rd(8'h13), "R4", d, exp_rd(8'h13));
    b_stop;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule